// File: doc/BRIEF.md
# Flash Command Interface with Block Lock Bits

This block decodes byte-wide bus writes aimed at a flash array and keeps the state that goes with them. It holds the read mode that selects what a read returns: the array contents, the status byte, or per-block lock information. It runs the two-write lock sequences. A first write of 60H arms the sequence. The second write either sets the lock bit of the addressed block (01H) or clears every lock bit (D0H). A timed busy window stands in for the internal write engine, and the lock bits change when that window ends.

Bus writes are strobed on `we_i` and sampled on the rising clock edge. The program-enable voltage flag gates any change to the lock bits. A supply-valid input and a power-down input force the interface back to array reads. Either one also cancels any sequence or operation in progress. A clear that is cut short this way leaves every block locked, so software must run the clear again.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, reads return array data, `sts_o` is 1, `status_o` is 80H and every lock bit is 0.
- R2: Writing 60H and then 01H with block address b, with `vpen_ok_i` high, sets lock bit b. The bit changes at the edge that ends the busy window. No other lock bit changes.
- R3: Writing 60H and then D0H, with `vpen_ok_i` high, clears all lock bits at the edge that ends the busy window.
- R4: After an accepted confirm write, `sts_o` and status bit 7 read 0 for exactly BUSY_CYCLES cycles. At all other times they read 1.
- R5: While busy, every write is ignored: the read mode does not change and no new sequence or operation starts.
- R6: Once 60H is accepted, reads return the status byte. They keep returning it after the second write, whatever that write holds.
- R7: A second write other than 01H or D0H sets status bit 4 (sequence error). It starts no busy window and changes no lock bit.
- R8: A valid confirm write made while `vpen_ok_i` is low sets status bit 3 (voltage error). It starts no busy window and changes no lock bit.
- R9: Writing FFH selects array reads (`rd_data_o` = `arr_data_i`). Writing 90H selects identifier reads (`rd_data_o` = {7'b0, lock bit at `addr_i`}). Any other first-cycle byte has no effect.
- R10: While `pwr_ok_i` is low or `pwrdn_i` is high, the interface returns to array reads, drops an armed sequence, ends any busy window and ignores writes.
- R11: If R10 ends a busy window of a clear operation, every lock bit becomes 1. If it ends a set operation, the lock bits stay unchanged.
- R12: Acceptance of 60H clears status bits 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Bus write strobe, one write per cycle high |
| addr_i | input | BLK_AW | Block address for confirm writes and identifier reads |
| data_i | input | 8 | Command byte |
| arr_data_i | input | 8 | Data from the array model |
| vpen_ok_i | input | 1 | Program-enable voltage valid |
| pwr_ok_i | input | 1 | Supply within valid range |
| pwrdn_i | input | 1 | Power-down request |
| rd_data_o | output | 8 | Read data for the current read mode |
| sts_o | output | 1 | Ready (1) or busy (0) |
| status_o | output | 8 | Status byte: bit 7 ready, bit 4 sequence error, bit 3 voltage error |
| lock_o | output | N_BLOCKS | Lock bit of each block |

## Verification
Lock sequences run on two different blocks, so the set path shows whether the target address is decoded. A set followed by a clear tells apart a clear that touches every block from one that touches only the last target. A bad confirm byte and a confirm made with the enable voltage low each show that a lock bit stays put and that the correct error bit is raised. Writes made during busy, and supply or power-down pulses during clear, set and armed phases, separate a real abort from a write that is silently dropped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_IDENT = 8'h90;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_SET_CONF   = 8'h01;
  localparam logic [7:0] CMD_CLR_CONF   = 8'hD0;

  localparam int unsigned SR_READY   = 7;
  localparam int unsigned SR_SEQ_ERR = 4;
  localparam int unsigned SR_VPP_ERR = 3;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned BLK_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        data_i,
  input  logic [BLK_AW-1:0] addr_i,
  input  logic              busy_i,
  input  logic              hold_i,
  input  logic              vpen_ok_i,
  output rd_mode_e          mode_o,
  output logic              start_set_o,
  output logic              start_clr_o,
  output logic [BLK_AW-1:0] tgt_o,
  output logic              seq_err_o,
  output logic              vpp_err_o
);
  rd_mode_e mode_q;
  logic     setup_q, seq_err_q, vpp_err_q;
  logic     wr_ok, conf_set, conf_clr;

  assign wr_ok    = we_i && !busy_i && !hold_i;
  assign conf_set = data_i == CMD_SET_CONF;
  assign conf_clr = data_i == CMD_CLR_CONF;

  assign start_set_o = wr_ok && setup_q && conf_set && vpen_ok_i;
  assign start_clr_o = wr_ok && setup_q && conf_clr && vpen_ok_i;
  assign tgt_o       = addr_i;
  assign mode_o      = mode_q;
  assign seq_err_o   = seq_err_q;
  assign vpp_err_o   = vpp_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_ARRAY;
      setup_q   <= 1'b0;
      seq_err_q <= 1'b0;
      vpp_err_q <= 1'b0;
    end else if (hold_i) begin
      mode_q  <= MODE_ARRAY;
      setup_q <= 1'b0;
    end else if (wr_ok) begin
      if (setup_q) begin
        setup_q <= 1'b0;
        mode_q  <= MODE_STATUS;
        if (!(conf_set || conf_clr)) seq_err_q <= 1'b1;
        else if (!vpen_ok_i)         vpp_err_q <= 1'b1;
      end else begin
        unique case (data_i)
          CMD_READ_ARRAY: mode_q <= MODE_ARRAY;
          CMD_READ_IDENT: mode_q <= MODE_IDENT;
          CMD_LOCK_SETUP: begin
            setup_q   <= 1'b1;
            mode_q    <= MODE_STATUS;
            seq_err_q <= 1'b0;
            vpp_err_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: supply loss or power-down forces array reads next cycle
  a_r10_hold_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> mode_q == MODE_ARRAY);
  // R6: an accepted operation leaves reads on status
  a_r6_status_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_set_o || start_clr_o) |=> mode_q == MODE_STATUS);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = cnt_q != '0;
  assign done_o = busy_o && !hold_i && cnt_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
    else if (start_i) cnt_q <= CW'(BUSY_CYCLES);
  end

  // R5: no operation may start while the engine is busy
  a_r5_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R4: the busy window shrinks by exactly one each cycle
  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !hold_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int unsigned N_BLOCKS = 8,
  parameter int unsigned BLK_AW   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_set_i,
  input  logic                start_clr_i,
  input  logic [BLK_AW-1:0]   tgt_i,
  input  logic                vpen_ok_i,
  input  logic                done_i,
  input  logic                abort_i,
  output logic [N_BLOCKS-1:0] lock_o
);
  logic              pend_set_q, pend_clr_q;
  logic [BLK_AW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_set_q <= 1'b0;
      pend_clr_q <= 1'b0;
      tgt_q      <= '0;
    end else if (done_i || abort_i) begin
      pend_set_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else if (start_set_i || start_clr_i) begin
      pend_set_q <= start_set_i;
      pend_clr_q <= start_clr_i;
      tgt_q      <= tgt_i;
    end
  end

  for (genvar i = 0; i < N_BLOCKS; i++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        lock_o[i] <= 1'b0;
      else if (abort_i && pend_clr_q)                     lock_o[i] <= 1'b1; // unknown -> locked
      else if (done_i && pend_clr_q)                      lock_o[i] <= 1'b0;
      else if (done_i && pend_set_q && tgt_q == BLK_AW'(i)) lock_o[i] <= 1'b1;
    end
  end

  // R8: operations only start with a valid enable voltage
  a_r8_vpen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_set_i || start_clr_i) |-> vpen_ok_i);
  // R11: an aborted clear leaves every block locked
  a_r11_clr_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && pend_clr_q) |=> &lock_o);
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int unsigned N_BLOCKS    = 8,
  parameter int unsigned BUSY_CYCLES = 6,
  localparam int unsigned BLK_AW     = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [BLK_AW-1:0]   addr_i,
  input  logic [7:0]          data_i,
  input  logic [7:0]          arr_data_i,
  input  logic                vpen_ok_i,
  input  logic                pwr_ok_i,
  input  logic                pwrdn_i,
  output logic [7:0]          rd_data_o,
  output logic                sts_o,
  output logic [7:0]          status_o,
  output logic [N_BLOCKS-1:0] lock_o
);
  rd_mode_e          mode;
  logic              hold, busy, done, start_set, start_clr, seq_err, vpp_err;
  logic [BLK_AW-1:0] tgt;

  assign hold = !pwr_ok_i || pwrdn_i;

  flash_cmd_decode #(.BLK_AW(BLK_AW)) u_decode (
    .clk_i, .rst_ni, .we_i, .data_i, .addr_i,
    .busy_i(busy), .hold_i(hold), .vpen_ok_i,
    .mode_o(mode), .start_set_o(start_set), .start_clr_o(start_clr),
    .tgt_o(tgt), .seq_err_o(seq_err), .vpp_err_o(vpp_err)
  );

  flash_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start_set || start_clr), .hold_i(hold),
    .busy_o(busy), .done_o(done)
  );

  flash_lock_bits #(.N_BLOCKS(N_BLOCKS), .BLK_AW(BLK_AW)) u_locks (
    .clk_i, .rst_ni, .start_set_i(start_set), .start_clr_i(start_clr),
    .tgt_i(tgt), .vpen_ok_i, .done_i(done), .abort_i(hold && busy),
    .lock_o
  );

  always_comb begin
    status_o             = '0;
    status_o[SR_READY]   = !busy;
    status_o[SR_SEQ_ERR] = seq_err;
    status_o[SR_VPP_ERR] = vpp_err;
  end

  assign sts_o = !busy;

  always_comb begin
    unique case (mode)
      MODE_STATUS: rd_data_o = status_o;
      MODE_IDENT:  rd_data_o = {7'b0, lock_o[addr_i]};
      default:     rd_data_o = arr_data_i;
    endcase
  end
endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int BC = 6;

  logic clk = 0, rst_n = 0;
  logic we = 0, vpen = 1, pwr = 1, pd = 0;
  logic [2:0] addr = 0;
  logic [7:0] data = 0, arr = 8'h3C;
  logic [7:0] rd, status;
  logic sts;
  logic [NB-1:0] lock;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_if #(.N_BLOCKS(NB), .BUSY_CYCLES(BC)) u_flash_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .data_i(data),
    .arr_data_i(arr), .vpen_ok_i(vpen), .pwr_ok_i(pwr), .pwrdn_i(pd),
    .rd_data_o(rd), .sts_o(sts), .status_o(status), .lock_o(lock)
  );

  // behavioural reference: 0 array, 1 status, 2 ident
  int m_mode, m_cnt;
  bit m_setup, m_seq, m_vpp, m_opclr;
  int m_tgt;
  logic [NB-1:0] m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_setup = 0; m_seq = 0; m_vpp = 0;
      m_opclr = 0; m_tgt = 0; m_lock = '0;
    end else if (!pwr || pd) begin
      if (m_cnt > 0 && m_opclr) m_lock = '1;
      m_cnt = 0; m_mode = 0; m_setup = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        if (m_opclr) m_lock = '0;
        else m_lock[m_tgt] = 1'b1;
      end
    end else if (we) begin
      if (m_setup) begin
        m_setup = 0; m_mode = 1;
        if (data != 8'h01 && data != 8'hD0) m_seq = 1;
        else if (!vpen) m_vpp = 1;
        else begin m_cnt = BC; m_opclr = (data == 8'hD0); m_tgt = addr; end
      end else if (data == 8'hFF) m_mode = 0;
      else if (data == 8'h90) m_mode = 2;
      else if (data == 8'h60) begin m_setup = 1; m_mode = 1; m_seq = 0; m_vpp = 0; end
    end
  end

  function automatic logic [7:0] m_status();
    return {m_cnt == 0, 2'b0, m_seq, m_vpp, 3'b0};
  endfunction

  function automatic logic [7:0] m_rd();
    if (m_mode == 1) return m_status();
    if (m_mode == 2) return {7'b0, m_lock[addr]};
    return arr;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    chk(32'(sts), 32'(m_cnt == 0), "R4 sts");
    chk(32'(status), 32'(m_status()), "R12 status");
    chk(32'(lock), 32'(m_lock), "R2 lock");
    chk(32'(rd), 32'(m_rd()), "R9 rd_data");
  end

  task automatic wr(input logic [7:0] d, input logic [2:0] a);
    @(negedge clk); #1;
    we = 1; data = d; addr = a;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(32'(status), 32'h80, "R1 status");
    chk(32'(rd), 32'h3C, "R1 array read");
    chk(32'(lock), 0, "R1 locks");

    wr(8'h90, 3'd3); @(negedge clk);
    chk(32'(rd), 0, "R9 ident");
    arr = 8'h5A; wr(8'hFF, 0); @(negedge clk);
    chk(32'(rd), 32'h5A, "R9 array");
    wr(8'h33, 0); @(negedge clk);
    chk(32'(rd), 32'h5A, "R9 unknown ignored");

    wr(8'h60, 0); @(negedge clk);
    chk(32'(rd), 32'h80, "R6 status after setup");
    wr(8'h01, 3'd3); @(negedge clk);
    chk(32'(sts), 0, "R4 busy");
    wr(8'hFF, 0); @(negedge clk);
    chk(32'(rd), 32'h00, "R5 write ignored while busy");
    idle(BC);
    chk(32'(lock), 32'h08, "R2 set block 3");
    chk(32'(rd), 32'h80, "R6 status stays");

    wr(8'h60, 0); wr(8'h01, 3'd5); idle(BC + 1);
    chk(32'(lock), 32'h28, "R2 set block 5");

    wr(8'h60, 0); wr(8'h77, 0); @(negedge clk);
    chk(32'(status), 32'h90, "R7 sequence error");
    chk(32'(lock), 32'h28, "R7 locks kept");
    wr(8'h60, 0); @(negedge clk);
    chk(32'(status), 32'h80, "R12 errors cleared");
    vpen = 0; wr(8'h01, 0); @(negedge clk);
    chk(32'(status), 32'h88, "R8 voltage error");
    chk(32'(lock), 32'h28, "R8 locks kept");
    vpen = 1;

    wr(8'h60, 0); wr(8'hD0, 0); idle(BC + 1);
    chk(32'(lock), 0, "R3 clear all");

    wr(8'h60, 0); wr(8'h01, 3'd1); idle(BC + 1);
    wr(8'h60, 0); wr(8'hD0, 0); idle(2);
    #1 pwr = 0; @(posedge clk); #1 pwr = 1; @(negedge clk);
    chk(32'(lock), 32'hFF, "R11 aborted clear");
    chk(32'(sts), 1, "R10 busy ended");
    chk(32'(rd), 32'h5A, "R10 array mode");
    wr(8'h60, 0); wr(8'hD0, 0); idle(BC + 1);
    chk(32'(lock), 0, "R11 clear again");

    wr(8'h60, 0); wr(8'h01, 3'd4); idle(2);
    #1 pd = 1; @(posedge clk); #1 pd = 0; @(negedge clk);
    chk(32'(lock), 0, "R11 aborted set");

    wr(8'h60, 0);
    @(negedge clk); #1 pd = 1;
    wr(8'h90, 0); @(negedge clk);
    chk(32'(rd), 32'h5A, "R10 write ignored in hold");
    #1 pd = 0;
    wr(8'h01, 3'd2); idle(BC + 1);
    chk(32'(lock), 0, "R10 armed sequence dropped");
    summary();
  end
endmodule